// File: doc/BRIEF.md
# Dynamically Controlled 64-bit Accumulator

This block is the accumulation stage that sits behind a multiplier or adder in an arithmetic datapath. Each cycle it takes one signed operand, widens it by sign extension to 64 bits, and writes a new value into its result register. Three control inputs select what happens that cycle: the register can take the operand alone, add it to the running total, subtract it from the running total, or take the operand plus a constant that has exactly one bit set.

The single-bit constant is used for rounding. Set the constant one position below the bit where the result will be cut, and a later truncation rounds to nearest instead of rounding down. The position comes from a 6-bit selector, so any bit of the 64-bit result can carry the offset. The control inputs can change every cycle. The result register has a clock enable and a synchronous active-low reset.

Top module: `acc64_dyn`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `acc_q` is zero after that edge, whatever the value of `en`.
- R2: When `en` is low and `rst_n` is high at a rising edge, `acc_q` keeps its value.
- R3: Control code {`ctl_sub`,`ctl_preset`,`ctl_feedback`} = 000 loads the sign-extended operand and discards the previous total.
- R4: Code 001 adds the sign-extended operand to the previous `acc_q`.
- R5: Code 101 adds the two's complement of the sign-extended operand to the previous `acc_q`, which subtracts the operand.
- R6: Code 010 loads the sign-extended operand plus 2^`pre_sel`, where `pre_sel` runs from 0 to 63.
- R7: Codes 011, 100, 110 and 111 behave exactly like code 000.
- R8: The operand is a signed two's complement value. Its top bit is copied into every upper bit of the 64-bit sum.
- R9: All arithmetic wraps modulo 2^64, with no saturation and no overflow flag.
- R10: The result has one cycle of latency and no bubbles. The operation selected in each enabled cycle uses the `acc_q` value written by the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Result register update enable |
| ctl_sub | input | 1 | Control bit: subtract the operand (first bit of the code) |
| ctl_preset | input | 1 | Control bit: add the one-hot preload constant (second bit of the code) |
| ctl_feedback | input | 1 | Control bit: feed the previous total back (third bit of the code) |
| pre_sel | input | 6 | Bit position of the preload constant |
| opd | input | 54 | Signed operand |
| acc_q | output | 64 | Registered accumulator value |

## Verification
Carry through all 64 bits is the hardest case to reach, because the operand is only 54 bits wide. The stimulus first loads an all-ones value by sign-extending a negative operand, then adds one to wrap the total to zero. It then subtracts from zero to wrap back the other way. It also preloads bit 63 directly, which is the only way to reach the top bit with a single set bit. Back-to-back cycles change the control code on every clock, which shows that each operation reads the total from the cycle just before it.

// File: rtl/acc64_pkg.sv
// Package: shared types for the dynamic accumulator.
// Assumes: consumers agree on the meaning of each mode below.
package acc64_pkg;

    // Operation applied to the result register in one enabled cycle.
    typedef enum logic [1:0] {
        ACC_MODE_LOAD   = 2'd0,  // result = operand
        ACC_MODE_ADD    = 2'd1,  // result = previous + operand
        ACC_MODE_SUB    = 2'd2,  // result = previous - operand
        ACC_MODE_PRESET = 2'd3   // result = operand + one-hot constant
    } acc_mode_e;

endpackage

// File: rtl/acc64_mode_decode.sv
// Module: acc64_mode_decode
// Maps the three per-cycle control bits to one accumulator mode.
// Assumes: every code not assigned a mode falls back to plain load.
module acc64_mode_decode
    import acc64_pkg::*;
(
    input  logic      ctl_sub,
    input  logic      ctl_preset,
    input  logic      ctl_feedback,
    output acc_mode_e mode
);

    // Decode the 3-bit code; unassigned codes behave as load.
    always_comb begin
        unique case ({ctl_sub, ctl_preset, ctl_feedback})
            3'b001:  mode = ACC_MODE_ADD;
            3'b101:  mode = ACC_MODE_SUB;
            3'b010:  mode = ACC_MODE_PRESET;
            default: mode = ACC_MODE_LOAD;
        endcase
    end

endmodule

// File: rtl/acc64_addend_gen.sv
// Module: acc64_addend_gen
// Produces the adder's right-hand terms: the sign-extended operand,
// inverted when subtracting (carry-in completes the two's complement),
// and a one-hot rounding constant that is nonzero only in preset mode.
// Assumes: ACC_W is a power of two and OPD_W < ACC_W.
module acc64_addend_gen
    import acc64_pkg::*;
#(
    parameter int ACC_W = 64,
    parameter int OPD_W = 54,
    localparam int SEL_W = $clog2(ACC_W)
) (
    input  logic [OPD_W-1:0] opd,
    input  logic [SEL_W-1:0] pre_sel,
    input  acc_mode_e        mode,
    output logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] pre_const,
    output logic             carry_in
);

    localparam int EXT_W = ACC_W - OPD_W;

    logic [ACC_W-1:0] opd_ext;
    logic             is_preset;

    // Widen the operand by replicating its sign bit.
    always_comb opd_ext = {{EXT_W{opd[OPD_W-1]}}, opd};

    // Invert for subtraction; the carry-in adds the missing one.
    always_comb begin
        addend   = (mode == ACC_MODE_SUB) ? ~opd_ext : opd_ext;
        carry_in = (mode == ACC_MODE_SUB);
    end

    // Flag cycles that take the rounding constant.
    always_comb is_preset = (mode == ACC_MODE_PRESET);

    // One comparator per bit builds the one-hot constant.
    for (genvar b = 0; b < ACC_W; b++) begin : g_onehot
        assign pre_const[b] = is_preset && (pre_sel == SEL_W'(b));
    end

    // Guard: preset mode must yield exactly one set bit (R6).
    always_comb begin
        if (is_preset) begin
            assert_preset_onehot_R6: assert ($countones(pre_const) == 1);
        end
    end

endmodule

// File: rtl/acc64_sum_unit.sv
// Module: acc64_sum_unit
// Gates the feedback path and forms the next accumulator value with a
// single wrap-around adder.
// Assumes: addend and constant come from acc64_addend_gen.
module acc64_sum_unit
    import acc64_pkg::*;
#(
    parameter int ACC_W = 64
) (
    input  logic [ACC_W-1:0] acc_prev,
    input  acc_mode_e        mode,
    input  logic [ACC_W-1:0] addend,
    input  logic [ACC_W-1:0] pre_const,
    input  logic             carry_in,
    output logic [ACC_W-1:0] acc_next
);

    logic [ACC_W-1:0] feedback;

    // Keep the previous total only in add and subtract modes.
    always_comb begin
        feedback = ((mode == ACC_MODE_ADD) || (mode == ACC_MODE_SUB))
                   ? acc_prev : '0;
    end

    // Sum all terms modulo 2^ACC_W.
    always_comb acc_next = feedback + addend + pre_const + ACC_W'(carry_in);

endmodule

// File: rtl/acc64_dyn.sv
// Module: acc64_dyn (top)
// Registered 64-bit accumulator whose operation is chosen every cycle
// by three control bits: load, add, subtract, or load with a one-hot
// rounding constant. One cycle of latency, no bubbles.
// Assumes: synchronous active-low reset, which overrides the enable.
module acc64_dyn
    import acc64_pkg::*;
#(
    parameter int ACC_W = 64,
    parameter int OPD_W = 54,
    localparam int SEL_W = $clog2(ACC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ctl_sub,
    input  logic             ctl_preset,
    input  logic             ctl_feedback,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic [OPD_W-1:0] opd,
    output logic [ACC_W-1:0] acc_q
);

    acc64_pkg::acc_mode_e mode;
    logic [ACC_W-1:0]     addend;
    logic [ACC_W-1:0]     pre_const;
    logic                 carry_in;
    logic [ACC_W-1:0]     acc_next;

    acc64_mode_decode u_decode (
        .ctl_sub      (ctl_sub),
        .ctl_preset   (ctl_preset),
        .ctl_feedback (ctl_feedback),
        .mode         (mode)
    );

    acc64_addend_gen #(
        .ACC_W (ACC_W),
        .OPD_W (OPD_W)
    ) u_addend (
        .opd       (opd),
        .pre_sel   (pre_sel),
        .mode      (mode),
        .addend    (addend),
        .pre_const (pre_const),
        .carry_in  (carry_in)
    );

    acc64_sum_unit #(
        .ACC_W (ACC_W)
    ) u_sum (
        .acc_prev  (acc_q),
        .mode      (mode),
        .addend    (addend),
        .pre_const (pre_const),
        .carry_in  (carry_in),
        .acc_next  (acc_next)
    );

    // Result register: reset clears it, the enable gates updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_next;
        end
    end

    // ---------------- assertions on the port behaviour ----------------
    logic [ACC_W-1:0] chk_ext;
    logic [2:0]       chk_code;

    // Checker-side view of the operand and the control code.
    always_comb begin
        chk_ext  = {{(ACC_W-OPD_W){opd[OPD_W-1]}}, opd};
        chk_code = {ctl_sub, ctl_preset, ctl_feedback};
    end

    assert_reset_clears_R1: assert property (
        @(posedge clk) !rst_n |=> acc_q == '0);

    assert_hold_when_idle_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));

    assert_load_plain_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (en && chk_code == 3'b000) |=> acc_q == $past(chk_ext));

    assert_add_prev_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (en && chk_code == 3'b001) |=> acc_q == $past(acc_q) + $past(chk_ext));

    assert_sub_prev_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (en && chk_code == 3'b101) |=> acc_q == $past(acc_q) - $past(chk_ext));

    assert_unlisted_as_load_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (en && (chk_code == 3'b011 || chk_code == 3'b100 ||
                chk_code == 3'b110 || chk_code == 3'b111))
        |=> acc_q == $past(chk_ext));

endmodule

// File: tb/acc64_dyn_test.sv
// Scoreboard bench: the driver pushes expected values, the monitor
// pops and compares them one cycle later.
module acc64_dyn_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic        ctl_sub, ctl_preset, ctl_feedback;
    logic [5:0]  pre_sel;
    logic [53:0] opd;
    logic [63:0] acc_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] model = '0;

    always #5 clk = ~clk;

    acc64_dyn uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .ctl_sub      (ctl_sub),
        .ctl_preset   (ctl_preset),
        .ctl_feedback (ctl_feedback),
        .pre_sel      (pre_sel),
        .opd          (opd),
        .acc_q        (acc_q)
    );

    // Apply one cycle of stimulus and queue its expected result.
    task automatic drive(input logic r, input logic e, input logic [2:0] code,
                         input logic [5:0] s, input logic [53:0] v,
                         input string tag);
        logic [63:0] ext;
        @(negedge clk);
        rst_n = r;
        en    = e;
        {ctl_sub, ctl_preset, ctl_feedback} = code;
        pre_sel = s;
        opd     = v;
        ext = {{10{v[53]}}, v};
        if (!r)       model = '0;
        else if (e) begin
            case (code)
                3'b001:  model = model + ext;
                3'b101:  model = model - ext;
                3'b010:  model = ext + (64'd1 << s);
                default: model = ext;
            endcase
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare away from the clock edge.
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [63:0] ev;
            string       tv;
            ev = exp_q.pop_front();
            tv = tag_q.pop_front();
            checks++;
            if (acc_q !== ev) begin
                errors++;
                $display("FAIL %s: acc_q=%h expected %h", tv, acc_q, ev);
            end
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; ctl_sub = 1'b0; ctl_preset = 1'b0;
        ctl_feedback = 1'b0; pre_sel = '0; opd = '0;
        drive(0, 0, 3'b000, 0, 54'd0, "R1 reset state");
        drive(0, 1, 3'b001, 0, 54'd9, "R1 reset with enable");
        // R3 / R8: load positive then negative operand
        drive(1, 1, 3'b000, 0, 54'd5, "R3 load positive");
        drive(1, 1, 3'b000, 0, -54'sd7, "R8 load sign-extended negative");
        // R4 accumulate run
        drive(1, 1, 3'b001, 0, 54'd100, "R4 add 100");
        drive(1, 1, 3'b001, 0, 54'd200, "R4 add 200");
        drive(1, 1, 3'b001, 0, -54'sd50, "R4 add -50");
        // R2 hold with busy inputs
        drive(1, 0, 3'b001, 0, 54'd777, "R2 hold add");
        drive(1, 0, 3'b000, 0, 54'd1, "R2 hold load");
        // R5 subtract
        drive(1, 1, 3'b101, 0, 54'd43, "R5 subtract 43");
        drive(1, 1, 3'b101, 0, -54'sd1000, "R5 subtract negative");
        // R6 preset at several positions
        drive(1, 1, 3'b010, 0, 54'd1, "R6 preset bit 0");
        drive(1, 1, 3'b010, 7, 54'd3, "R6 preset bit 7");
        drive(1, 1, 3'b010, 63, 54'd0, "R6 preset bit 63");
        drive(1, 1, 3'b010, 40, -54'sd1, "R6 preset bit 40 negative");
        // R7 unlisted codes behave as load
        drive(1, 1, 3'b001, 0, 54'd11, "R7 prime total");
        drive(1, 1, 3'b011, 5, 54'd21, "R7 code 011");
        drive(1, 1, 3'b001, 0, 54'd11, "R7 prime total");
        drive(1, 1, 3'b100, 0, 54'd22, "R7 code 100");
        drive(1, 1, 3'b110, 9, 54'd23, "R7 code 110");
        drive(1, 1, 3'b111, 9, -54'sd24, "R7 code 111");
        // R9 wrap both directions
        drive(1, 1, 3'b000, 0, -54'sd1, "R9 load all ones");
        drive(1, 1, 3'b001, 0, 54'd1, "R9 wrap to zero");
        drive(1, 1, 3'b101, 0, 54'd1, "R9 wrap below zero");
        drive(1, 1, 3'b010, 63, 54'd0, "R9 preset top bit");
        drive(1, 1, 3'b001, 0, -54'sd1, "R9 add across top");
        // R10 code changes every cycle
        drive(1, 1, 3'b000, 0, 54'd1000, "R10 load");
        drive(1, 1, 3'b001, 0, 54'd24, "R10 add");
        drive(1, 1, 3'b101, 0, 54'd4, "R10 sub");
        drive(1, 1, 3'b010, 3, 54'd2, "R10 preset");
        drive(1, 1, 3'b001, 0, 54'd6, "R10 add after preset");
        drive(1, 0, 3'b101, 0, 54'd6, "R2 hold in sequence");
        drive(1, 1, 3'b101, 0, 54'd16, "R10 sub after hold");
        drive(0, 0, 3'b001, 0, 54'd5, "R1 reset without enable");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule